// File: doc/BRIEF.md
# Fast-Lock Timeout Sequencer

This block times the fast-lock phase of a fractional-N synthesizer loop. It watches 24-bit configuration words that an upstream shifter has already gathered into parallel form. Words tagged as timer-setup words load one of three 9-bit timeout values. Words tagged as the main frequency word start a new fast-lock sequence.

When a sequence starts, each timer counts its value down. The counters advance once every four reference (phase-detector) clock cycles. Two of the timers each hold a loop-switch enable high while they run. The third timer holds the charge-pump current at its boost level. When that timer expires, the current is stepped down by halves until it reaches the nominal level.

The current scale leaves the block as an exponent code. The code value c stands for a multiplier of 2^c, so 6 means 64x and 0 means 1x.

Top module: `fastlock_seq`

## Requirements
- R1: A word presented with `wr_valid` high and bits [2:0] = 3'b100 is a timer-setup word. Bits [13:5] carry a value V from 0 to 511. Bits [4:3] pick the timer: 00 is the SW3 timer, 01 is the SW1/SW2 timer and 10 is the charge-pump (ICP) timer. A stored value takes effect at the next sequence start.
- R2: A timer-setup word with bits [4:3] = 11 changes no stored value. The content of bits [23:14] has no effect on behaviour.
- R3: A word presented with `wr_valid` high and bits [2:0] = 3'b000 starts a sequence. It reloads all three counters from the stored values and restarts the divide-by-four tick phase.
- R4: `sw3_en` is high at the first clock edge that captures the start word. It stays high for exactly 4×V3 cycles and then drops. If V3 = 0, it stays low.
- R5: `sw12_en` behaves as in R4, using the SW1/SW2 value V12.
- R6: Take k as the number of cycles since the start edge. While k < 4×Vi, `icp_scale` is 6. After that, it takes the values 5, 4, 3, 2 and 1 for four cycles each, then stays at 0. With Vi = 0, the code is 5 at the start edge.
- R7: A start word that arrives during a running sequence abandons it. Timing then restarts from R4 to R6 with the current stored values.
- R8: A synchronous active-high `rst` clears all stored values, drives both switch enables low and sets `icp_scale` to 0.
- R9: A timer-setup word that arrives during a running sequence leaves that sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | `wr_word` holds a complete word this cycle |
| wr_word | input | 24 | Assembled configuration word |
| sw12_en | output | 1 | Closes the SW1/SW2 loop switches |
| sw3_en | output | 1 | Closes the SW3 loop switch |
| icp_scale | output | 3 | Charge-pump current exponent (multiplier 2^code) |

## Verification
The assertions assume that at most one word arrives per cycle and that `rst` is held from time zero. They also assume a tick never coincides with a start word. The prescaler guarantees that last point, because a start word suppresses the tick.

The bench drives one write at a time, each lasting a single cycle. It writes mid-sequence words only at a chosen cycle offset. It compares every cycle of each sequence against closed-form expressions of k and the stored values.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int WORD_W   = 24;
  localparam int CTL_W    = 3;
  localparam int SEL_LSB  = 3;
  localparam int SEL_W    = 2;
  localparam int VAL_LSB  = 5;
  localparam int TMR_W    = 9;
  localparam int NUM_TMR  = 3;
  localparam int TICK_DIV = 4;
  localparam int RAMP_STEPS = 6;

  localparam logic [CTL_W-1:0] CTL_START = 3'b000;
  localparam logic [CTL_W-1:0] CTL_TIMER = 3'b100;

  typedef enum logic [SEL_W-1:0] {
    SEL_SW3  = 2'b00,
    SEL_SW12 = 2'b01,
    SEL_ICP  = 2'b10,
    SEL_NONE = 2'b11
  } tmr_sel_e;

  function automatic logic [CTL_W-1:0] ctl_of(input logic [WORD_W-1:0] w);
    return w[CTL_W-1:0];
  endfunction

  function automatic logic [SEL_W-1:0] sel_of(input logic [WORD_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic [TMR_W-1:0] val_of(input logic [WORD_W-1:0] w);
    return w[VAL_LSB +: TMR_W];
  endfunction
endpackage

// File: rtl/fl_regdec.sv
module fl_regdec
  import fl_pkg::*;
#(
  parameter int TW = TMR_W,
  parameter int NT = NUM_TMR
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic [WORD_W-1:0]          wr_word,
  output logic                       restart,
  output logic [NT-1:0][TW-1:0]      loads
);
  logic timer_hit;
  logic bad_sel;

  assign restart   = wr_valid && (ctl_of(wr_word) == CTL_START);
  assign timer_hit = wr_valid && (ctl_of(wr_word) == CTL_TIMER);
  assign bad_sel   = timer_hit && (sel_of(wr_word) == SEL_NONE);

  for (genvar i = 0; i < NT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        loads[i] <= '0;
      end else if (timer_hit && (sel_of(wr_word) == SEL_W'(i))) begin
        loads[i] <= val_of(wr_word)[TW-1:0];
      end
    end
  end

  assert_unused_sel_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    bad_sel |=> $stable(loads));
  assert_start_keeps_values_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> $stable(loads));
endmodule

// File: rtl/fl_prescale.sv
module fl_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] phase;

  assign tick = (phase == PW'(DIV - 1)) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (phase == PW'(DIV - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_restart_phase_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/fl_down_timer.sv
module fl_down_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] load,
  output logic          active,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign active = (cnt != '0);
  assign expire = tick && !restart && (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= load;
    end else if (tick && active) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_drop_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(tick || restart));
  assert_start_level_R4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (active == ($past(load) != '0)));
  assert_expire_ends_R5: assert property (@(posedge clk) disable iff (rst)
    expire |=> !active);
endmodule

// File: rtl/fl_ramp.sv
module fl_ramp #(
  parameter int STEPS = 6,
  parameter int CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic          zero_load,
  input  logic          icp_active,
  input  logic          icp_expire,
  output logic [CW-1:0] code
);
  localparam logic [CW-1:0] TOP   = CW'(STEPS);
  localparam logic [CW-1:0] FIRST = CW'(STEPS - 1);

  logic stepping;
  assign stepping = tick && !icp_active && (code != '0) && (code != TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
    end else if (restart) begin
      code <= zero_load ? FIRST : TOP;
    end else if (icp_expire) begin
      code <= FIRST;
    end else if (stepping) begin
      code <= code - 1'b1;
    end
  end

  assert_ramp_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && !$past(rst) && (code != $past(code))) |->
      (code == CW'($past(code) - 1'b1)));
  assert_abort_raises_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (code >= FIRST));
  assert_boost_held_R6: assert property (@(posedge clk) disable iff (rst)
    (icp_active && !restart && !icp_expire) |=> $stable(code));
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq
  import fl_pkg::*;
#(
  parameter int TW    = TMR_W,
  parameter int DIV   = TICK_DIV,
  parameter int STEPS = RAMP_STEPS,
  parameter int CW    = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic              sw12_en,
  output logic              sw3_en,
  output logic [CW-1:0]     icp_scale
);
  logic                       restart;
  logic                       tick;
  logic [NUM_TMR-1:0][TW-1:0] loads;
  logic [NUM_TMR-1:0]         active;
  logic [NUM_TMR-1:0]         expire;

  fl_regdec #(.TW(TW), .NT(NUM_TMR)) u_dec (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
    .restart(restart), .loads(loads)
  );

  fl_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    fl_down_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst(rst), .restart(restart), .tick(tick),
      .load(loads[i]), .active(active[i]), .expire(expire[i])
    );
  end

  fl_ramp #(.STEPS(STEPS), .CW(CW)) u_ramp (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .zero_load(loads[SEL_ICP] == '0),
    .icp_active(active[SEL_ICP]), .icp_expire(expire[SEL_ICP]),
    .code(icp_scale)
  );

  assign sw3_en  = active[SEL_SW3];
  assign sw12_en = active[SEL_SW12];

  assert_reset_state_R8: assert property (@(posedge clk)
    $past(rst) |-> (!sw3_en && !sw12_en && icp_scale == '0));
  assert_start_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    restart |-> !tick);
endmodule

// File: tb/tb_fastlock_seq.sv
module tb_fastlock_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [23:0] wr_word = '0;
  logic        sw12_en, sw3_en;
  logic [2:0]  icp_scale;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int m3 = 0, m12 = 0, mi = 0;

  localparam logic [23:0] START_W = 24'h5A3C08;

  always #2 clk = ~clk;

  fastlock_seq dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
    .sw12_en(sw12_en), .sw3_en(sw3_en), .icp_scale(icp_scale)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired: actual cycles %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [23:0] tword(int sel, int val, int rsv);
    return {rsv[9:0], val[8:0], sel[1:0], 3'b100};
  endfunction

  function automatic int exp_sw(int k, int v);
    return (k < 4 * v) ? 1 : 0;
  endfunction

  function automatic int exp_code(int k, int vi);
    int d;
    if (k < 4 * vi) return 6;
    d = (k - 4 * vi) / 4;
    return (d >= 5) ? 0 : 5 - d;
  endfunction

  task automatic model_write(logic [23:0] w);
    if (w[2:0] == 3'b100) begin
      case (w[4:3])
        2'b00: m3 = int'(w[13:5]);
        2'b01: m12 = int'(w[13:5]);
        2'b10: mi = int'(w[13:5]);
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(logic [23:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_word = w;
    model_write(w);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_seq(string tag, int ncyc, int mid_k, logic [23:0] mid_w);
    int a3, a12, ai;
    do_write(START_W);
    a3 = m3; a12 = m12; ai = mi;
    for (int k = 0; k < ncyc; k++) begin
      check({tag, " R4 sw3_en"}, int'(sw3_en), exp_sw(k, a3));
      check({tag, " R5 sw12_en"}, int'(sw12_en), exp_sw(k, a12));
      check({tag, " R6 icp_scale"}, int'(icp_scale), exp_code(k, ai));
      if (k == mid_k) begin
        wr_valid = 1'b1;
        wr_word = mid_w;
        model_write(mid_w);
      end else begin
        wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  function automatic int seq_len(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return 4 * m + 28;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset sw3_en", int'(sw3_en), 0);
    check("R8 reset sw12_en", int'(sw12_en), 0);
    check("R8 reset icp_scale", int'(icp_scale), 0);
    run_seq("R8 cleared values", 30, -1, '0);

    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        do_write(tword(0, a, 1));
        do_write(tword(1, b, 1));
        do_write(tword(2, (a + 2 * b) % 7, 1));
        run_seq("R1 sweep", seq_len(a, b, (a + 2 * b) % 7), -1, '0);
      end
    end

    do_write(tword(0, 511, 1));
    do_write(tword(1, 500, 1));
    do_write(tword(2, 504, 1));
    run_seq("R1 max", seq_len(511, 500, 504), -1, '0);

    do_write(tword(0, 5, 1));
    do_write(tword(1, 6, 1));
    do_write(tword(2, 3, 1));
    do_write(tword(3, 40, 10'h3FF));
    do_write(tword(1, 6, 10'h2AA));
    run_seq("R2 sel11+reserved", seq_len(5, 6, 3), -1, '0);

    run_seq("R7 abort first", 15, -1, '0);
    run_seq("R7 restart", seq_len(5, 6, 3), -1, '0);

    run_seq("R9 midwrite", seq_len(5, 6, 3), 6, tword(2, 1, 1));
    run_seq("R3 new values", seq_len(5, 6, 1), -1, '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule